// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register Block

This block holds the 16-bit control registers of a simple Ethernet controller and turns software commands into work for the engines around it. A word-wide register bus reaches it. The register index is the bus address shifted right by `ADDR_SHIFT` bits, so the same block fits buses of different byte granularity. A write to the command register at index 0x00 latches the command bits. In the cycle that follows, each accepted command bit appears as a single-cycle pulse on `cmdAct`. The engines that carry the commands out are halt-transmit, transmit, receiver control, timer control, resource fetch and address-filter load.

Each register has its own write rule. Some registers accept writes only while the controller is held in software reset. Others mask off low bits, store the inverse of the written value, ignore writes, or clear bits where ones are written. The transmit, resource-fetch, address-load and halt-transmit bits stay set in the command register until their engine reports completion on `cmdDone`. Software can therefore see that the work is still pending. Engines raise interrupt causes through `isrSet`. The level interrupt `irq` is high while any unmasked cause is pending.

Top module: `netctl_regs`

## Requirements
- R1: After hardware reset, command (0x00) reads 0x0094, receive control (0x02) reads 0x0020, end-of-buffer count (0x13) reads 0x02F8, every other storage register reads 0, and `cmdAct` and `irq` are low.
- R2: The register index is `busAddr >> ADDR_SHIFT` (6 bits), so address bits below the shift select nothing.
- R3: While command bit 7 (reset) is set, a command write that lacks bit 7 only clears bit 7. It latches no other bit and pulses nothing.
- R4: An accepted command write ORs `busWdata & 0x03BF` into the command register. In the next cycle, and only then, `cmdAct[9:0]` equals those bits at the same positions.
- R5: Bit 3 (receiver enable) clears bit 2 (receiver disable), and bit 2 clears bit 3. Bit 5 (start timer) clears bit 4 (stop timer), and bit 4 clears bit 5. Writing both bits of a pair clears both.
- R6: A command with bit 7 clears bits 0, 1, 8 and 9, and sets bits 7 and 2.
- R7: `cmdDone` bits 0, 1, 8 and 9 clear the matching command bits. Its other bits have no effect.
- R8: Configuration register 0x01 (mask 0xBFFF) and 0x3F (mask 0xF017) change only while command bit 7 is set.
- R9: Writes keep only bits 15:12 of 0x03, bits 15:5 of 0x02, bits 14:0 of 0x04, and clear bit 0 of the pointer registers 0x15 to 0x18. Other plain registers store the written value.
- R10: Counters 0x2C to 0x2E store the bitwise inverse of the written value.
- R11: Indices 0x22 to 0x24, 0x28 and 0x2F ignore writes. 0x28 reads 0x0004 and the others read 0.
- R12: Status 0x05 clears where ones are written, and `isrSet` ORs bits in, with set winning over clear. Clearing a set bit 5 pulses `cmdAct[8]` in the next cycle.
- R13: `irq` is high exactly when mask (0x04) AND status (0x05) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busAddr | input | ADDR_W | Register bus address |
| busWr | input | 1 | Write strobe, one word per cycle |
| busWdata | input | 16 | Write data |
| rdData | output | 16 | Read data for the addressed register |
| cmdDone | input | 10 | Engine completion strobes, command bit positions |
| isrSet | input | 16 | Interrupt cause set strobes |
| cmdAct | output | 10 | One-cycle command action pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `ADDR_SHIFT` = 2 and `ADDR_W` = 8, and sets both address bits below the index on most accesses. A decoder that failed to shift, or that shifted by the default amount, would then land on the wrong register. The 6-bit index fills the upper field completely, so the largest index, 0x3F, is reachable. The configuration write tests run once inside the reset state and once outside it. Command sequences are chosen so that every pair of bits that clear each other, the reset override and the swallowed command each change the command register visibly.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int REG_W    = 16;
  localparam int IDX_W    = 6;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int ACT_W    = 10;

  localparam int IDX_CMD    = 'h00;
  localparam int IDX_DCFG   = 'h01;
  localparam int IDX_RXCTL  = 'h02;
  localparam int IDX_TXCTL  = 'h03;
  localparam int IDX_IMASK  = 'h04;
  localparam int IDX_ISTAT  = 'h05;
  localparam int IDX_EOBC   = 'h13;
  localparam int IDX_PTR_LO = 'h15;
  localparam int IDX_PTR_HI = 'h18;
  localparam int IDX_CAMP_LO = 'h22;
  localparam int IDX_CAMP_HI = 'h24;
  localparam int IDX_REV    = 'h28;
  localparam int IDX_TAL_LO = 'h2C;
  localparam int IDX_TAL_HI = 'h2E;
  localparam int IDX_RSVD   = 'h2F;
  localparam int IDX_DCFG2  = 'h3F;

  localparam int BIT_RXDIS  = 2;
  localparam int BIT_RXEN   = 3;
  localparam int BIT_TSTOP  = 4;
  localparam int BIT_TSTART = 5;
  localparam int BIT_RESET  = 7;
  localparam int BIT_RDRES  = 8;
  localparam int ISR_RBE    = 5;

  localparam logic [REG_W-1:0] CMD_ACCEPT = 16'h03BF;
  localparam logic [REG_W-1:0] CMD_ENGINE = 16'h0303;
  localparam logic [REG_W-1:0] CMD_SRST_SET = 16'h0084;
  localparam logic [REG_W-1:0] CMD_RST_VAL = 16'h0094;
  localparam logic [REG_W-1:0] REV_VAL    = 16'h0004;

  typedef struct packed {
    logic             regWr;
    logic [IDX_W-1:0] regIdx;
    logic [REG_W-1:0] regData;
    logic             inReset;
  } regStrobe_t;

  function automatic bit isReadOnly(int idx);
    return (idx >= IDX_CAMP_LO && idx <= IDX_CAMP_HI) || idx == IDX_REV || idx == IDX_RSVD;
  endfunction

  function automatic logic [REG_W-1:0] roValue(int idx);
    return (idx == IDX_REV) ? REV_VAL : '0;
  endfunction

  function automatic bit isCfgOnly(int idx);
    return idx == IDX_DCFG || idx == IDX_DCFG2;
  endfunction

  function automatic logic [REG_W-1:0] writeMask(int idx);
    if (idx == IDX_DCFG)  return 16'hBFFF;
    if (idx == IDX_DCFG2) return 16'hF017;
    if (idx == IDX_TXCTL) return 16'hF000;
    if (idx == IDX_RXCTL) return 16'hFFE0;
    if (idx == IDX_IMASK) return 16'h7FFF;
    if (idx >= IDX_PTR_LO && idx <= IDX_PTR_HI) return 16'hFFFE;
    return 16'hFFFF;
  endfunction

  function automatic logic [REG_W-1:0] invertMask(int idx);
    return (idx >= IDX_TAL_LO && idx <= IDX_TAL_HI) ? 16'hFFFF : 16'h0000;
  endfunction

  function automatic logic [REG_W-1:0] resetValue(int idx);
    if (idx == IDX_RXCTL) return 16'h0020;
    if (idx == IDX_EOBC)  return 16'h02F8;
    return '0;
  endfunction
endpackage

// File: rtl/netctl_ctrl.sv
module netctl_ctrl
  import netctl_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int ADDR_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [REG_W-1:0]     busWdata,
  input  logic [ACT_W-1:0]     cmdDone,
  input  logic                 rbeCleared,
  output regStrobe_t           strobe,
  output logic [REG_W-1:0]     cmdReg,
  output logic [ACT_W-1:0]     cmdAct
);
  logic [ADDR_W-1:0] idxWide;
  logic [IDX_W-1:0]  regIdx;
  logic              cmdWr;
  logic              swallow;
  logic              accept;
  logic [REG_W-1:0]  accBits;
  logic [REG_W-1:0]  cmdNext;
  logic [ACT_W-1:0]  actNext;

  assign idxWide = busAddr >> ADDR_SHIFT;
  assign regIdx  = idxWide[IDX_W-1:0];

  always_comb begin
    cmdWr   = busWr && (regIdx == IDX_W'(IDX_CMD));
    swallow = cmdWr && cmdReg[BIT_RESET] && !busWdata[BIT_RESET];
    accept  = cmdWr && !swallow;
    accBits = busWdata & CMD_ACCEPT;
    cmdNext = cmdReg & ~({{(REG_W-ACT_W){1'b0}}, cmdDone} & CMD_ENGINE);
    if (swallow) begin
      cmdNext[BIT_RESET] = 1'b0;
    end else if (accept) begin
      cmdNext = cmdNext | accBits;
      if (accBits[BIT_RXDIS])  cmdNext[BIT_RXEN]   = 1'b0;
      if (accBits[BIT_RXEN])   cmdNext[BIT_RXDIS]  = 1'b0;
      if (accBits[BIT_TSTOP])  cmdNext[BIT_TSTART] = 1'b0;
      if (accBits[BIT_TSTART]) cmdNext[BIT_TSTOP]  = 1'b0;
      if (accBits[BIT_RESET]) begin
        cmdNext = (cmdNext & ~CMD_ENGINE) | CMD_SRST_SET;
      end
    end
    actNext = accept ? accBits[ACT_W-1:0] : '0;
    actNext[BIT_RDRES] = actNext[BIT_RDRES] | rbeCleared;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= CMD_RST_VAL;
      cmdAct <= '0;
    end else begin
      cmdReg <= cmdNext;
      cmdAct <= actNext;
    end
  end

  assign strobe.regWr   = busWr;
  assign strobe.regIdx  = regIdx;
  assign strobe.regData = busWdata;
  assign strobe.inReset = cmdReg[BIT_RESET];
endmodule

// File: rtl/netctl_dp.sv
module netctl_dp
  import netctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] cmdReg,
  input  logic [REG_W-1:0] isrSet,
  output logic [REG_W-1:0] rdData,
  output logic             rbeCleared,
  output logic             irq
);
  logic [REG_W-1:0] regQ [NUM_REGS];
  logic [REG_W-1:0] isrClr;

  assign isrClr = (strobe.regWr && strobe.regIdx == IDX_W'(IDX_ISTAT)) ? strobe.regData : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    if (g == IDX_CMD) begin : gCmd
      assign regQ[g] = cmdReg;
    end else if (isReadOnly(g)) begin : gRo
      assign regQ[g] = roValue(g);
    end else if (g == IDX_ISTAT) begin : gIsr
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= (q & ~isrClr) | isrSet;
      end
      assign regQ[g] = q;
    end else begin : gRw
      localparam logic [REG_W-1:0] RST_V  = resetValue(g);
      localparam logic [REG_W-1:0] MASK_V = writeMask(g);
      localparam logic [REG_W-1:0] INV_V  = invertMask(g);
      localparam bit               CFG_V  = isCfgOnly(g);
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = strobe.regWr && (strobe.regIdx == IDX_W'(g)) && (!CFG_V || strobe.inReset);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    q <= RST_V;
        else if (hit) q <= (strobe.regData ^ INV_V) & MASK_V;
      end
      assign regQ[g] = q;
    end
  end

  assign rdData     = regQ[strobe.regIdx];
  assign rbeCleared = isrClr[ISR_RBE] & regQ[IDX_ISTAT][ISR_RBE];
  assign irq        = |(regQ[IDX_IMASK] & regQ[IDX_ISTAT]);
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
  import netctl_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int ADDR_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       rdData,
  input  logic [9:0]        cmdDone,
  input  logic [15:0]       isrSet,
  output logic [9:0]        cmdAct,
  output logic              irq
);
  regStrobe_t       strobe;
  logic [REG_W-1:0] cmdReg;
  logic             rbeCleared;

  netctl_ctrl #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .cmdDone(cmdDone), .rbeCleared(rbeCleared),
    .strobe(strobe), .cmdReg(cmdReg), .cmdAct(cmdAct)
  );

  netctl_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdReg(cmdReg),
    .isrSet(isrSet), .rdData(rdData), .rbeCleared(rbeCleared), .irq(irq)
  );
endmodule

// File: rtl/netctl_regs_chk.sv
module netctl_regs_chk #(
  parameter int ADDR_W     = 7,
  parameter int ADDR_SHIFT = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [15:0]       busWdata,
  input logic [9:0]        cmdDone,
  input logic [15:0]       isrSet,
  input logic [9:0]        cmdAct,
  input logic              irq,
  input logic [15:0]       cmdReg
);
  logic [ADDR_W-1:0] idxWide;
  logic [5:0]        idx;
  logic              cmdWr;
  assign idxWide = busAddr >> ADDR_SHIFT;
  assign idx     = idxWide[5:0];
  assign cmdWr   = busWr && idx == 6'h00;

  // R4
  act_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAct != 10'd0) |-> $past(busWr));

  // R3
  swallow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdReg[7] && !busWdata[7]) |=> (cmdAct == 10'd0 && !cmdReg[7]));

  // R6
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata[7]) |=> (cmdReg[7] && cmdReg[2] && (cmdReg & 16'h0303) == 16'h0000));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && cmdDone[1]) |=> !cmdReg[1]);

  // R5
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !cmdReg[7] && busWdata[3] && !busWdata[2] && !busWdata[7]) |=> !cmdReg[2]);

  // R13
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busWr || isrSet != 16'h0000));
endmodule

bind netctl_regs netctl_regs_chk #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .cmdDone(cmdDone), .isrSet(isrSet), .cmdAct(cmdAct), .irq(irq), .cmdReg(cmdReg)
);

// File: tb/netctl_regs_bench.sv
module netctl_regs_bench;
  localparam int AW = 8;
  localparam int SH = 2;
  localparam int NVEC = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWr = 1'b0;
  logic [15:0]   busWdata = '0;
  logic [15:0]   rdData;
  logic [9:0]    cmdDone = '0;
  logic [15:0]   isrSet = '0;
  logic [9:0]    cmdAct;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  netctl_regs #(.ADDR_W(AW), .ADDR_SHIFT(SH)) u_netctl_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .rdData(rdData), .cmdDone(cmdDone), .isrSet(isrSet), .cmdAct(cmdAct), .irq(irq)
  );

  // index, write data, expected readback (all taken inside reset state)
  localparam logic [37:0] VEC [NVEC] = '{
    {6'h03, 16'hFFFF, 16'hF000},  // R9
    {6'h02, 16'hFFFF, 16'hFFE0},  // R9
    {6'h04, 16'hFFFF, 16'h7FFF},  // R9
    {6'h15, 16'h1235, 16'h1234},  // R9
    {6'h18, 16'hFFFF, 16'hFFFE},  // R9
    {6'h06, 16'hABCD, 16'hABCD},  // R9
    {6'h13, 16'h1111, 16'h1111},  // R9
    {6'h2C, 16'h00FF, 16'hFF00},  // R10
    {6'h2E, 16'h1234, 16'hEDCB},  // R10
    {6'h23, 16'hFFFF, 16'h0000},  // R11
    {6'h28, 16'h0000, 16'h0004},  // R11
    {6'h2F, 16'hFFFF, 16'h0000},  // R11
    {6'h01, 16'hFFFF, 16'hBFFF},  // R8
    {6'h3F, 16'hFFFF, 16'hF017}   // R8
  };

  function automatic logic [AW-1:0] addrOf(logic [5:0] idx, logic [1:0] lo);
    return {idx, lo};
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] idx, logic [15:0] d, logic [1:0] lo = 2'b11);
    @(negedge clk);
    busAddr = addrOf(idx, lo);
    busWdata = d;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [5:0] idx, output logic [15:0] v, input logic [1:0] lo = 2'b11);
    busAddr = addrOf(idx, lo);
    #1;
    v = rdData;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check("R1 cmd", v, 16'h0094);
    rd(6'h02, v); check("R1 rxctl", v, 16'h0020);
    rd(6'h13, v); check("R1 eobc", v, 16'h02F8);
    rd(6'h05, v); check("R1 istat", v, 16'h0000);
    rd(6'h06, v); check("R1 plain", v, 16'h0000);
    check("R1 act", {6'd0, cmdAct}, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // table of per-register write rules
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][37:32], VEC[i][31:16]);
      rd(VEC[i][37:32], v);
      check("R8-R11 table", v, VEC[i][15:0]);
    end

    // R2 low address bits select nothing
    wr(6'h07, 16'h5A5A, 2'b00);
    rd(6'h07, v, 2'b11); check("R2 index", v, 16'h5A5A);
    rd(6'h06, v, 2'b10); check("R2 neighbour", v, 16'hABCD);

    // R3 swallowed command
    wr(6'h00, 16'h0002);
    check("R3 act", {6'd0, cmdAct}, 16'h0000);
    rd(6'h00, v); check("R3 cmd", v, 16'h0014);

    // R8 config writes ignored outside reset
    wr(6'h01, 16'h0000); rd(6'h01, v); check("R8 dcfg locked", v, 16'hBFFF);
    wr(6'h3F, 16'h0000); rd(6'h3F, v); check("R8 dcfg2 locked", v, 16'hF017);

    // R4 accepted command and pulse
    wr(6'h00, 16'h0222);
    check("R4 act", {6'd0, cmdAct}, 16'h0222);
    rd(6'h00, v); check("R4 cmd", v, 16'h0226);
    @(negedge clk);
    check("R4 act one cycle", {6'd0, cmdAct}, 16'h0000);
    wr(6'h00, 16'h0040);
    check("R4 masked act", {6'd0, cmdAct}, 16'h0000);
    rd(6'h00, v); check("R4 masked cmd", v, 16'h0226);

    // R7 engine done strobes
    @(negedge clk); cmdDone = 10'h3FF;
    @(negedge clk); cmdDone = '0;
    rd(6'h00, v); check("R7 done", v, 16'h0024);

    // R5 exclusive pairs
    wr(6'h00, 16'h0008); rd(6'h00, v); check("R5 rx enable", v, 16'h0028);
    wr(6'h00, 16'h0010); rd(6'h00, v); check("R5 timer stop", v, 16'h0018);
    wr(6'h00, 16'h000C); rd(6'h00, v); check("R5 both rx", v, 16'h0010);

    // R6 software reset
    wr(6'h00, 16'h0301); rd(6'h00, v); check("R6 pre", v, 16'h0311);
    wr(6'h00, 16'h0080);
    check("R6 act", {6'd0, cmdAct}, 16'h0080);
    rd(6'h00, v); check("R6 cmd", v, 16'h0094);
    wr(6'h00, 16'h0008); rd(6'h00, v); check("R3 again", v, 16'h0014);

    // R12 status register and R13 interrupt
    @(negedge clk); isrSet = 16'h0060;
    @(negedge clk); isrSet = '0;
    rd(6'h05, v); check("R12 set", v, 16'h0060);
    check("R13 irq on", {15'd0, irq}, 16'h0001);
    wr(6'h05, 16'h0040);
    check("R12 no fetch", {6'd0, cmdAct}, 16'h0000);
    rd(6'h05, v); check("R12 w1c", v, 16'h0020);
    wr(6'h05, 16'h0020);
    check("R12 fetch pulse", {6'd0, cmdAct}, 16'h0100);
    rd(6'h05, v); check("R12 cleared", v, 16'h0000);
    check("R13 irq off", {15'd0, irq}, 16'h0000);
    wr(6'h05, 16'h0020);
    check("R12 clear of clear bit", {6'd0, cmdAct}, 16'h0000);

    @(negedge clk);
    busAddr = addrOf(6'h05, 2'b01); busWdata = 16'h0080; busWr = 1'b1; isrSet = 16'h0080;
    @(negedge clk);
    busWr = 1'b0; isrSet = '0;
    rd(6'h05, v); check("R12 set wins", v, 16'h0080);

    wr(6'h04, 16'h0000); check("R13 masked", {15'd0, irq}, 16'h0000);
    wr(6'h04, 16'h0080); check("R13 unmasked", {15'd0, irq}, 16'h0001);
    wr(6'h04, 16'h0040); check("R13 other mask", {15'd0, irq}, 16'h0000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule